// File: doc/BRIEF.md
# Three-Phase Capacitor Bank Switching Sequencer

This block decides, cycle by cycle, which thyristor valves of a three-phase capacitor bank receive trigger pulses. Once a switch-on request is accepted, each phase is fired only when its own zero-voltage detector reports that the voltage across its valve is zero. The phases close in a fixed order: first the pair formed by phases A and C, then phase B. A phase that has fired keeps its trigger pulses for as long as the request stays active, so the valve stays conducting. The pulses stop in the same cycle the request goes away, and the valves then turn off at the next current zero.

The sequencer also protects the valves. If one phase is not fired within a time limit, the whole switch-on is abandoned. Over-current, loss of conduction on a fired phase, and over-voltage on a valve that has not fired yet each remove every trigger in the same cycle. Each of these cases also latches a fault with a 2-bit cause code. A latched fault refuses new switch-on requests until it is cleared explicitly.

Top module: `cap_switch_seq`

## Requirements
- R1: While the sequencer is switching on and the request is active (`sw_on`=1, `sw_off`=0), a trigger for phase A (bit 0) or phase C (bit 2) is asserted in the same cycle that the phase's `zv_rdy` bit is high. With no accepted request, no trigger is ever asserted.
- R2: The `zv_rdy` bit of phase B (bit 1) is ignored until phases A and C have both fired in an earlier cycle. A trigger on B only ever appears together with triggers on A and C.
- R3: A phase that has fired keeps its trigger asserted in every later cycle while the request stays active, whatever its `zv_rdy` input does.
- R4: Dropping `sw_on` or raising `sw_off` clears all triggers in the same cycle, latches no fault, and returns the sequencer to idle. Every phase must then see a new zero-voltage ready before it fires again.
- R5: If all three phases have not fired within TMO_CYC cycles after a switch-on request is accepted, all triggers drop and a fault is latched with code 2'b00.
- R6: A `cond_lost` bit on a phase that has fired, while the request is active, clears all triggers in the same cycle and latches code 2'b01. When `sw_off` is present, a loss of conduction latches no fault.
- R7: `over_cur` clears all triggers in the same cycle and latches code 2'b10, in any state.
- R8: `over_volt` on a phase that has not fired, either when the request is accepted or while switching on, prevents triggering and latches code 2'b11.
- R9: A latched fault holds its first code until `fault_clr` is asserted. It keeps all triggers low and refuses switch-on requests. After the clear, a request that is still active is accepted again.
- R10: After reset, all triggers are low, `fault` is 0 and `fault_code` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_on | input | 1 | Switch-on request (level) |
| sw_off | input | 1 | Switch-off command, overrides `sw_on` |
| zv_rdy | input | 3 | Per-phase zero-voltage ready (bit0 A, bit1 B, bit2 C) |
| over_volt | input | 3 | Per-phase valve over-voltage flag |
| over_cur | input | 1 | Over-current indication |
| cond_lost | input | 3 | Per-phase conduction interruption |
| fault_clr | input | 1 | Clears the latched fault |
| trig_en | output | 3 | Per-phase trigger-pulse enable |
| fault | output | 1 | Latched fault |
| fault_code | output | 2 | Cause: 00 timeout, 01 interruption, 10 over-current, 11 over-voltage |

## Verification
The bench builds the sequencer with TMO_CYC=6. With a window that short, a full sweep is practical: the ready pulses of phases A, C and B are each placed at every cycle from 1 to 7 after acceptance. That covers every ordering of the three phases, B arriving too early, and pulses landing on, inside and just outside the timeout boundary. Directed sequences then cover withdrawal, loss of conduction with and without `sw_off`, over-current in the idle and switching states, over-voltage at acceptance and during switching, and fault stickiness and clear.

// File: rtl/cs_pkg.sv
// Shared types for the capacitor switching sequencer.
package cs_pkg;
    localparam int NUM_PH = 3;
    localparam int PH_A   = 0;
    localparam int PH_B   = 1;
    localparam int PH_C   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_ON   = 2'd2
    } seq_st_t;

    typedef enum logic [1:0] {
        FC_TIMEOUT   = 2'b00,
        FC_INTERRUPT = 2'b01,
        FC_OVERCUR   = 2'b10,
        FC_OVERVOLT  = 2'b11
    } fault_code_t;
endpackage

// File: rtl/cs_phase_gate.sv
// Trigger gate for one phase.
// Fires when the phase is armed and its zero-voltage ready is high, then
// remembers that it fired so the trigger is held while 'hold' stays true.
// Assumes 'hold' already contains every kill condition of the top level.
module cs_phase_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hold,
    input  logic release_i,
    input  logic rdy,
    output logic trig,
    output logic fired
);
    logic fired_q;

    // Trigger: a held phase that has fired, or an armed phase that sees ready now.
    always_comb begin
        trig = hold & (fired_q | (arm & rdy));
    end

    // Fired memory: set on a trigger, cleared when the sequencer returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)         fired_q <= 1'b0;
        else if (release_i) fired_q <= 1'b0;
        else if (trig)      fired_q <= 1'b1;
    end

    assign fired = fired_q;

    // R3: a phase that triggered and is not released counts as fired next cycle.
    assert_fire_memo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !release_i) |=> fired_q);
endmodule

// File: rtl/cs_fire_timer.sv
// Switch-on timeout counter.
// Counts the cycles spent in the switching state and flags expiry in the
// LIM-th cycle. Assumes LIM >= 1; the counter restarts whenever run drops.
module cs_fire_timer #(
    parameter int LIM = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIM > 1) ? $clog2(LIM) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIM - 1);

    logic [CW-1:0] cnt_q;

    // Expiry: the current switching cycle is the last one allowed.
    always_comb begin
        expired = run && (cnt_q == LAST);
    end

    // Counter: zero outside the switching state, counts up to LAST inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    // R5: the counter never passes the programmed limit.
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/cs_fault_latch.sv
// Sticky fault flag with cause code.
// The first cause is kept; later causes only keep the flag set. A set in
// the same cycle as a clear wins over the clear.
module cs_fault_latch
    import cs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set,
    input  fault_code_t set_code,
    input  logic        clr,
    output logic        fault,
    output fault_code_t code
);
    logic        fault_q;
    fault_code_t code_q;

    // Latch: record the first cause, hold until an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            code_q  <= FC_TIMEOUT;
        end else if (set) begin
            fault_q <= 1'b1;
            if (!fault_q) code_q <= set_code;
        end else if (clr) begin
            fault_q <= 1'b0;
        end
    end

    assign fault = fault_q;
    assign code  = code_q;

    // R9: a fault stays set until it is cleared.
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !clr) |=> fault_q);
    // R9: the code of a held fault does not change.
    assert_code_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !clr) |=> $stable(code_q));
endmodule

// File: rtl/cap_switch_seq.sv
// Three-phase capacitor bank switching sequencer (top).
// Accepts a level switch-on request, fires phases A and C on their own
// zero-voltage ready, then phase B, and holds the triggers until the request
// is withdrawn. Aborts on timeout, and kills every trigger combinationally on
// over-current, loss of conduction or over-voltage, latching a fault code.
// Assumes all inputs are synchronous to clk.
module cap_switch_seq
    import cs_pkg::*;
#(
    parameter int TMO_CYC = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_on,
    input  logic                sw_off,
    input  logic [NUM_PH-1:0]   zv_rdy,
    input  logic [NUM_PH-1:0]   over_volt,
    input  logic                over_cur,
    input  logic [NUM_PH-1:0]   cond_lost,
    input  logic                fault_clr,
    output logic [NUM_PH-1:0]   trig_en,
    output logic                fault,
    output logic [1:0]          fault_code
);
    seq_st_t          st_q, st_d;
    logic             active_on, ov_hit, intr_hit, kill, hold, release_all;
    logic             all_now, expired, f_set, fault_q;
    fault_code_t      f_code, code_q;
    logic [NUM_PH-1:0] arm, fired, trig;

    // Request and kill conditions seen in the current cycle.
    always_comb begin
        active_on = sw_on & ~sw_off;
        ov_hit    = |(over_volt & ~fired);
        intr_hit  = (st_q != ST_IDLE) & active_on & (|(cond_lost & fired));
        kill      = over_cur | intr_hit | (ov_hit & (st_q == ST_ARM));
        hold      = (st_q != ST_IDLE) & active_on & ~kill & ~fault_q;
        all_now   = &(fired | trig);
    end

    // Arming: A and C while switching, B only after both have fired.
    generate
        for (genvar p = 0; p < NUM_PH; p++) begin : g_arm
            if (p == PH_B) begin : g_second
                assign arm[p] = (st_q == ST_ARM) & fired[PH_A] & fired[PH_C];
            end else begin : g_first
                assign arm[p] = (st_q == ST_ARM);
            end
        end
    endgenerate

    // Per-phase trigger gates.
    generate
        for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
            cs_phase_gate u_gate (
                .clk       (clk),
                .rst_n     (rst_n),
                .arm       (arm[p]),
                .hold      (hold),
                .release_i (release_all),
                .rdy       (zv_rdy[p]),
                .trig      (trig[p]),
                .fired     (fired[p])
            );
        end
    endgenerate

    cs_fire_timer #(.LIM(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_ARM),
        .expired (expired)
    );

    // Sequencer next state and fault cause, highest priority first.
    always_comb begin
        st_d   = st_q;
        f_set  = 1'b0;
        f_code = FC_TIMEOUT;
        if (st_q == ST_IDLE) begin
            if (over_cur) begin
                f_set = 1'b1; f_code = FC_OVERCUR;
            end else if (!fault_q && active_on) begin
                if (ov_hit) begin
                    f_set = 1'b1; f_code = FC_OVERVOLT;
                end else begin
                    st_d = ST_ARM;
                end
            end
        end else begin
            if (over_cur) begin
                f_set = 1'b1; f_code = FC_OVERCUR; st_d = ST_IDLE;
            end else if (!active_on) begin
                st_d = ST_IDLE;
            end else if (intr_hit) begin
                f_set = 1'b1; f_code = FC_INTERRUPT; st_d = ST_IDLE;
            end else if (st_q == ST_ARM && ov_hit) begin
                f_set = 1'b1; f_code = FC_OVERVOLT; st_d = ST_IDLE;
            end else if (st_q == ST_ARM && all_now) begin
                st_d = ST_ON;
            end else if (st_q == ST_ARM && expired) begin
                f_set = 1'b1; f_code = FC_TIMEOUT; st_d = ST_IDLE;
            end
        end
        release_all = (st_d == ST_IDLE);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    cs_fault_latch u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (f_set),
        .set_code (f_code),
        .clr      (fault_clr),
        .fault    (fault_q),
        .code     (code_q)
    );

    assign trig_en    = trig;
    assign fault      = fault_q;
    assign fault_code = code_q;

    // R2: phase B never triggers without A and C.
    assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_en[PH_B] |-> (trig_en[PH_A] && trig_en[PH_C]));
    // R4: no trigger without an active request.
    assert_withdraw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_on && !sw_off) |-> (trig_en == '0));
    // R7: over-current removes all triggers at once.
    assert_ovc_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        over_cur |-> (trig_en == '0));
    // R7: over-current always leaves a fault behind.
    assert_ovc_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        over_cur |=> fault);
    // R9: a latched fault keeps every trigger low.
    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (trig_en == '0));
endmodule

// File: tb/cap_switch_seq_tb_top.sv
// Bench: sweeps ready-pulse timing of all three phases, then walks the fault cases.
module cap_switch_seq_tb_top;
    localparam int L = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_on = 1'b0, sw_off = 1'b0, over_cur = 1'b0, fault_clr = 1'b0;
    logic [2:0] zv_rdy = '0, over_volt = '0, cond_lost = '0;
    logic [2:0] trig_en;
    logic       fault;
    logic [1:0] fault_code;
    int         n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    cap_switch_seq #(.TMO_CYC(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .sw_off(sw_off),
        .zv_rdy(zv_rdy), .over_volt(over_volt), .over_cur(over_cur),
        .cond_lost(cond_lost), .fault_clr(fault_clr),
        .trig_en(trig_en), .fault(fault), .fault_code(fault_code)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge, then settle.
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear_all();
        cyc(); sw_on = 0; sw_off = 0; zv_rdy = 0; over_volt = 0; over_cur = 0;
        cond_lost = 0; fault_clr = 1;
        cyc(); fault_clr = 0;
        cyc();
    endtask

    // Accept a request and fire A+C then B; returns with the bank fully on.
    task automatic bring_on();
        cyc(); sw_on = 1; zv_rdy = 3'b000;
        cyc(); zv_rdy = 3'b101; #2 chk("R1", {1'b0, trig_en}, 4'h5);
        cyc(); zv_rdy = 3'b010; #2 chk("R2", {1'b0, trig_en}, 4'h7);
        cyc(); zv_rdy = 3'b000; #2 chk("R3", {1'b0, trig_en}, 4'h7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        #2 chk("R10", {trig_en, fault}, 4'h0);
        chk("R10", {2'b00, fault_code}, 4'h0);
        rst_n = 1;
        cyc(); #2 chk("R1", {1'b0, trig_en}, 4'h0);

        // Sweep: A, C and B ready pulses each at every cycle 1..L+1.
        for (int da = 1; da <= L + 1; da++)
        for (int dc = 1; dc <= L + 1; dc++)
        for (int db = 1; db <= L + 1; db++) begin
            logic fa, fb, fc, failed, ta, tb, tc;
            fa = 0; fb = 0; fc = 0; failed = 0;
            cyc(); sw_on = 1; zv_rdy = 0; #2 chk("R1", {1'b0, trig_en}, 4'h0);
            for (int c = 1; c <= L + 2; c++) begin
                cyc();
                zv_rdy = {c == dc, c == db, c == da};
                #2;
                if (failed) begin
                    ta = 0; tb = 0; tc = 0;
                end else begin
                    ta = fa | (c == da);
                    tc = fc | (c == dc);
                    tb = fb | ((c == db) & fa & fc);
                end
                chk("R1/R2/R3/R5 trig", {1'b0, trig_en}, {1'b0, tc, tb, ta});
                chk("R5 fault", {3'b000, fault}, {3'b000, failed});
                if (!failed) begin
                    fa = ta; fb = tb; fc = tc;
                    if (!(fa & fb & fc) && c == L) failed = 1;
                end
            end
            cyc(); sw_on = 0; zv_rdy = 0; #2 chk("R4", {1'b0, trig_en}, 4'h0);
            if (failed) chk("R5 code", {2'b00, fault_code}, 4'h0);
            clear_all();
        end

        // R4: switch-off in the on state.
        bring_on();
        cyc(); sw_off = 1; #2 chk("R4", {1'b0, trig_en}, 4'h0);
        cyc(); sw_off = 0; #2 chk("R4", {3'b000, fault}, 4'h0);
        cyc(); #2 chk("R4 refire", {1'b0, trig_en}, 4'h0);
        clear_all();

        // R6: conduction lost without switch-off.
        bring_on();
        cyc(); cond_lost = 3'b100; #2 chk("R6", {1'b0, trig_en}, 4'h0);
        cyc(); cond_lost = 0; #2 chk("R6", {1'b0, fault, fault_code}, 4'h5);
        clear_all();

        // R6: conduction lost together with switch-off.
        bring_on();
        cyc(); sw_off = 1; cond_lost = 3'b100; #2 chk("R6 off", {1'b0, trig_en}, 4'h0);
        cyc(); sw_off = 0; cond_lost = 0; sw_on = 0; #2 chk("R6 off", {3'b000, fault}, 4'h0);
        clear_all();

        // R7: over-current while switching, after A fired.
        cyc(); sw_on = 1;
        cyc(); zv_rdy = 3'b001; #2 chk("R7", {1'b0, trig_en}, 4'h1);
        cyc(); zv_rdy = 0; over_cur = 1; #2 chk("R7", {1'b0, trig_en}, 4'h0);
        cyc(); over_cur = 0; #2 chk("R7", {1'b0, fault, fault_code}, 4'h6);
        clear_all();

        // R7: over-current while idle.
        cyc(); over_cur = 1;
        cyc(); over_cur = 0; #2 chk("R7 idle", {1'b0, fault, fault_code}, 4'h6);
        clear_all();

        // R8 at acceptance, then R9 stickiness, blocking and clear.
        cyc(); sw_on = 1; over_volt = 3'b010;
        cyc(); zv_rdy = 3'b101; #2 chk("R8", {1'b0, trig_en}, 4'h0);
        chk("R8", {1'b0, fault, fault_code}, 4'h7);
        cyc(); over_cur = 1; over_volt = 0;
        cyc(); over_cur = 0; #2 chk("R9 code", {1'b0, fault, fault_code}, 4'h7);
        cyc(); #2 chk("R9 block", {1'b0, trig_en}, 4'h0);
        fault_clr = 1; zv_rdy = 0;
        cyc(); fault_clr = 0; #2 chk("R9 clr", {3'b000, fault}, 4'h0);
        cyc(); zv_rdy = 3'b101; #2 chk("R9 rearm", {1'b0, trig_en}, 4'h5);
        clear_all();

        // R8 during switching on a phase not yet fired.
        cyc(); sw_on = 1;
        cyc(); zv_rdy = 3'b001; #2 chk("R8 arm", {1'b0, trig_en}, 4'h1);
        cyc(); zv_rdy = 0; over_volt = 3'b100; #2 chk("R8 arm", {1'b0, trig_en}, 4'h0);
        cyc(); over_volt = 0; #2 chk("R8 arm", {1'b0, fault, fault_code}, 4'h7);
        clear_all();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule